// File: doc/BRIEF.md
# Fractional-Prescaler Baud Rate Generator

This block derives serial bit timing from the system clock. The clock first goes through a prescaler whose divide factor P can be a half-integer. The prescaler's strobes then go through an integer divisor N. The resulting single-cycle strobe, `tick_o`, runs at clk/(N×P). In asynchronous mode this is the 16× oversampling clock. In synchronous mode it is twice the bit rate. A second strobe, `bit_o`, marks every bit period. It is one `tick_o` in 16 in asynchronous mode and one in 2 in synchronous mode.

Half-step prescale factors bring the achieved rate much closer to common baud rates than integer division alone. For example, a 5 MHz clock with P = 6.5 and N = 5 gives a bit period of 520 clocks, which is 9615.385 baud, 0.16 % off 9600. A half-step factor is produced by alternating short and long prescaler periods. The average period is exact, and every strobe stays one clock wide. Synchronous mode accepts only integer factors, so a half-step code is rounded up.

Top module: `baud_gen`

## Requirements
- R1: While `rst_ni` is low, `tick_o` and `bit_o` are 0 and all counters are cleared. After release with code 1 and divisor 0, the first `tick_o` appears within 3 clocks.
- R2: Prescaler code 0 disables the block: no `tick_o` and no `bit_o` appear while it is selected.
- R3: Code k gives P = (k+1)/2. For odd k in asynchronous mode, every `tick_o` interval is exactly N×P clocks.
- R4: For even k ≥ 2 in asynchronous mode, the prescaler alternates periods of floor(P) and ceil(P). Any two consecutive `tick_o` intervals sum to N×(k+1) clocks. Each single interval lies between N×floor(P) and N×ceil(P).
- R5: In synchronous mode (`sync_mode_i` = 1), an even code k is rounded up to P = k/2+1, and every `tick_o` interval equals N×P exactly.
- R6: N = `div_i` + 1. With `div_i` = 0, every prescaler strobe reaches `tick_o`, so the interval is P clocks.
- R7: `bit_o` fires once every 16 `tick_o` in asynchronous mode and once every 2 in synchronous mode, always in the same cycle as a `tick_o`.
- R8: With code 12 (P = 6.5) and `div_i` = 4 in asynchronous mode, the `bit_o` period is 520 clocks. With code 25 (P = 13) and `div_i` = 1, it is 416 clocks.
- R9: A change to the code, the divisor or the mode is taken up by each counter at its next terminal count. From the third `tick_o` after the change onward, intervals follow the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc_code_i | input | PSC_W | Prescaler code k, P = (k+1)/2, 0 = off |
| div_i | input | DIV_W | Divisor value, N = div_i + 1 |
| sync_mode_i | input | 1 | 0 = asynchronous (16×), 1 = synchronous (2×) |
| tick_o | output | 1 | Oversample strobe, one clock wide |
| bit_o | output | 1 | Bit-period strobe, coincides with tick_o |

## Verification
Both strobes are registered one clock after the internal terminal counts. Any fixed latency therefore cancels, and the bench measures only spans between successive strobes, sampled on the falling edge. After every configuration change the bench discards a few strobes, because each counter adopts the new setting only at its own terminal count. Measurement starts once R9 guarantees the new rate. Reset and disable behaviour are checked on the very next falling edge, because the reset is asynchronous and the output register clears one clock after the code goes to 0.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } baud_mode_e;

  localparam int unsigned OS_ASYNC = 16;
  localparam int unsigned OS_SYNC  = 2;
endpackage

// File: rtl/baud_psc.sv
module baud_psc #(
  parameter int unsigned PSC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] code_i,
  input  logic             sync_i,
  output logic             strb_o
);
  localparam int unsigned CW = PSC_W + 1;

  logic [CW-1:0] cnt_q, cnt_d, base, per;
  logic          phase_q, phase_d;
  logic          en, half, half_alt, round_up, term;

  always_comb begin
    en       = (code_i != '0);
    base     = ({1'b0, code_i} + CW'(1)) >> 1;  // floor(P)
    half     = en && !code_i[0];
    half_alt = half && !sync_i;                 // alternate floor/ceil
    round_up = half && sync_i;                  // sync: integer only
    per      = base + CW'(round_up || (half_alt && phase_q));
    term     = en && (cnt_q >= per - CW'(1));
    strb_o   = term;
  end

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!en) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (term) begin
      cnt_d   = '0;
      phase_d = half_alt ? !phase_q : 1'b0;
    end else begin
      cnt_d   = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  a_r2_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> (cnt_q == '0 && !phase_q));

  a_r3_wrap_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o |=> (cnt_q == '0));

  a_r4_phase_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_o && half_alt) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             term_o
);
  logic [DIV_W-1:0] dcnt_q;

  assign term_o = stb_i && (dcnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= '0;
    else if (term_o)  dcnt_q <= '0;
    else if (stb_i)   dcnt_q <= dcnt_q + DIV_W'(1);
  end

  a_r6_wrap_after_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> (dcnt_q == '0));

  a_r6_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(dcnt_q));
endmodule

// File: rtl/baud_bit.sv
module baud_bit
  import baud_pkg::*;
#(
  parameter int unsigned OS_A = OS_ASYNC,
  parameter int unsigned OS_S = OS_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sync_i,
  output logic term_o
);
  localparam int unsigned OS_MAX = (OS_A > OS_S) ? OS_A : OS_S;
  localparam int unsigned BW     = (OS_MAX > 2) ? $clog2(OS_MAX) : 1;

  logic [BW-1:0] bcnt_q, last;

  assign last   = sync_i ? BW'(OS_S - 1) : BW'(OS_A - 1);
  assign term_o = tick_i && (bcnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bcnt_q <= '0;
    else if (term_o)  bcnt_q <= '0;
    else if (tick_i)  bcnt_q <= bcnt_q + BW'(1);
  end

  a_r7_wrap_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> (bcnt_q == '0));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned PSC_W = 5,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_code_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sync_mode_i,
  output logic             tick_o,
  output logic             bit_o
);
  baud_mode_e mode;
  logic       psc_stb, div_term, bit_term;

  assign mode = baud_mode_e'(sync_mode_i);

  baud_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (psc_code_i),
    .sync_i (mode == MODE_SYNC),
    .strb_o (psc_stb)
  );

  baud_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (psc_stb),
    .div_i  (div_i),
    .term_o (div_term)
  );

  baud_bit #(.OS_A(OS_ASYNC), .OS_S(OS_SYNC)) u_bit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (div_term),
    .sync_i (mode == MODE_SYNC),
    .term_o (bit_term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      tick_o <= div_term;
      bit_o  <= bit_term;
    end
  end

  a_r6_tick_from_psc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(psc_stb));

  a_r7_bit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> tick_o);
endmodule

// File: tb/baud_gen_test.sv
module baud_gen_test;
  localparam int CLK_P = 10;
  localparam int PSC_W = 5;
  localparam int DIV_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [PSC_W-1:0] psc_code_i = 5'd1;
  logic [DIV_W-1:0] div_i = '0;
  logic             sync_mode_i = 1'b0;
  logic             tick_o, bit_o;

  baud_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .psc_code_i(psc_code_i),
    .div_i(div_i), .sync_mode_i(sync_mode_i), .tick_o(tick_o), .bit_o(bit_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  longint cyc = 0;
  always @(posedge clk_i) cyc++;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output longint t, output bit ok);
    int g = 0;
    do begin @(negedge clk_i); g++; end while (!tick_o && g < 20000);
    ok = tick_o;
    t  = cyc;
  endtask

  task automatic next_bit(output longint t, output bit ok);
    int g = 0;
    do begin @(negedge clk_i); g++; end while (!bit_o && g < 20000);
    ok = bit_o;
    t  = cyc;
  endtask

  task automatic set_cfg(input int code, input int dv, input bit sm);
    @(negedge clk_i);
    psc_code_i  = PSC_W'(code);
    div_i       = DIV_W'(dv);
    sync_mode_i = sm;
  endtask

  // R3/R4/R5/R6/R9: interval checks for one configuration
  task automatic run_cfg(input int code, input int dv, input bit sm);
    longint t[6];
    bit ok;
    longint n, lo, hi, iv, span;
    string tag;
    set_cfg(code, dv, sm);
    for (int i = 0; i < 3; i++) begin
      longint d; next_tick(d, ok);
      if (!ok) begin chk(0, "R9 tick timeout", 0, 1); return; end
    end
    for (int i = 0; i < 6; i++) begin
      next_tick(t[i], ok);
      if (!ok) begin chk(0, "R9 tick timeout", 0, 1); return; end
    end
    n = dv + 1;
    if (sm) begin
      longint p = (code % 2 == 0) ? code / 2 + 1 : (code + 1) / 2;
      lo = n * p; hi = lo;
      tag = (code % 2 == 0) ? "R5 sync rounded" : "R5 sync integer";
    end else begin
      lo = n * ((code + 1) / 2);
      hi = n * ((code + 2) / 2);
      tag = (code % 2 == 0) ? "R4 half-step interval" : "R3 integer interval";
    end
    if (dv == 0) tag = {tag, " R6 pass-through"};
    for (int i = 1; i < 6; i++) begin
      iv = t[i] - t[i-1];
      chk(iv >= lo && iv <= hi, tag, iv, lo);
    end
    if (!sm) begin
      for (int i = 2; i < 6; i++) begin
        span = t[i] - t[i-2];
        chk(span == n * (code + 1), "R4 pair span", span, n * (code + 1));
      end
    end
  endtask

  // R7/R8: bit period
  task automatic run_bit(input int code, input int dv, input bit sm,
                         input longint exp, input string tag);
    longint t0, t1;
    bit ok;
    set_cfg(code, dv, sm);
    next_bit(t0, ok); next_bit(t0, ok); next_bit(t0, ok);
    chk(tick_o, "R7 bit coincides with tick", tick_o, 1);
    next_bit(t1, ok);
    chk(ok && (t1 - t0) == exp, tag, t1 - t0, exp);
    chk(tick_o, "R7 bit coincides with tick", tick_o, 1);
  endtask

  initial begin
    #(longint'(CLK_P) * 190000);
    chk(0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    longint t0, t1;
    int seen;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(!tick_o && !bit_o, "R1 quiet in reset", tick_o, 0);
    end
    rst_ni = 1'b1;
    t0 = cyc;
    next_tick(t1, ok);
    chk(ok && (t1 - t0) <= 3, "R1 first tick after release", t1 - t0, 3);

    // R3/R4/R6/R9 asynchronous sweep
    for (int c = 1; c < 8; c++)
      for (int d = 0; d < 4; d++)
        run_cfg(c, d, 1'b0);

    // R5 synchronous sweep
    for (int c = 1; c < 7; c++)
      for (int d = 0; d < 3; d++)
        run_cfg(c, d, 1'b1);

    // R7 bit ratios
    run_bit(3, 0, 1'b0, 16 * 2, "R7 async 16 ticks per bit");
    run_bit(5, 1, 1'b1, 2 * 2 * 3, "R7 sync 2 ticks per bit");
    run_bit(4, 0, 1'b1, 2 * 3, "R7 R5 sync rounded bit");

    // R8 worked examples
    run_bit(12, 4, 1'b0, 520, "R8 P=6.5 N=5 bit period");
    run_bit(25, 1, 1'b0, 416, "R8 P=13 N=2 bit period");

    // R2: code 0 disables
    set_cfg(0, 2, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (tick_o || bit_o) seen++;
    end
    chk(seen == 0, "R2 no strobes when off", seen, 0);

    // R1: reset mid-run
    set_cfg(1, 0, 1'b0);
    next_tick(t1, ok);
    #1 rst_ni = 1'b0;
    #1 chk(!tick_o && !bit_o, "R1 async clear mid-run", tick_o, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!tick_o && !bit_o, "R1 held in reset", tick_o, 0);
    end
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule